// File: doc/BRIEF.md
# Speculation-Tracking Load/Store Queue

This block is a circular load/store queue that lets a memory access leave the core before its address translation is confirmed. When the translation buffer misses but finds a nearby mapping, the predicted physical address goes into a new queue entry with a speculation flag set, and the access is issued at once. When the page walk finishes, the walker's verification carries the entry index and the true physical address, and the queue compares the two.

If they agree, the speculation flag clears and the entry may retire as normal. If they disagree, there are two cases. When the data has not yet come back, the queue quietly reissues the access with the corrected address and discards the stale reply. When the data has already come back, the queue raises a flush request that names the offending entry, and that entry and all younger ones are dropped. Every request carries an entry index and a one-bit generation, so a reply to a superseded request can be recognised and ignored. Entries retire strictly in order from the head.

Top module: `spec_lsq`

## Requirements
- R1: When `alloc_valid` is high and `alloc_ok` is high, the entry at the tail is filled and `mem_req_valid` rises in the same cycle. That request carries the tail index, the entry's newly toggled generation bit (0 after reset, so the first use of an entry sends 1) and `alloc_pa`. `alloc_ok` is low while all DEPTH (default 48) entries are occupied, and also in any cycle that raises a flush.
- R2: An entry allocated with `alloc_spec`=1 holds a speculation flag. While the flag is set, the entry never retires, even after its data has returned.
- R3: A data reply (`rsp_valid`, `rsp_idx`, `rsp_gen`) marks an entry's data as returned only if the entry is occupied, its data has not already returned and `rsp_gen` equals the generation of its latest request. Any other reply has no effect.
- R4: A verification whose `ver_pa` equals a speculative entry's stored address clears the flag. The entry can then retire once its data has returned.
- R5: A mismatching verification of a speculative entry whose data has returned drives `flush_valid` high for one cycle on the following cycle, with `flush_idx` equal to the entry's index. That entry and every younger entry are discarded, and the next allocation reuses that index.
- R6: A mismatching verification of a speculative entry whose data has not returned drives `reissue_valid` high for one cycle on the following cycle, with `reissue_idx` set to the entry, `reissue_pa` set to the true address and `reissue_gen` set to the toggled generation. The entry stores the true address and is no longer speculative. Replies carrying the old generation are ignored, and the reply carrying the new one is accepted.
- R7: When a reply and a mismatching verification reach the same entry in the same cycle, the reply is dropped and the reissue path of R6 is taken. No flush occurs.
- R8: `commit_valid` is high exactly when the head entry is occupied, has its data and is not speculative, with `commit_idx` = head and `commit_pa` = its stored address. The entry leaves the queue at that clock edge. A ready younger entry waits behind a head that is not ready.
- R9: A verification that addresses a non-speculative or empty entry has no effect: no flush, no reissue and no change of the stored address.
- R10: After reset the queue is empty, `alloc_ok` is high and `commit_valid`, `flush_valid` and `reissue_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to enter a new access |
| alloc_pa | input | PA_W | Physical address of the new access (predicted or exact) |
| alloc_spec | input | 1 | The address came from a speculative translation |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| mem_req_valid | output | 1 | Memory request for the newly allocated entry |
| mem_req_pa | output | PA_W | Address of that request |
| mem_req_idx | output | IDX_W | Entry index tagged on the request |
| mem_req_gen | output | 1 | Generation tagged on the request |
| rsp_valid | input | 1 | Data reply from memory |
| rsp_idx | input | IDX_W | Entry index of the reply |
| rsp_gen | input | 1 | Generation of the reply |
| ver_valid | input | 1 | Verification from the page walker |
| ver_idx | input | IDX_W | Entry being verified |
| ver_pa | input | PA_W | True physical address |
| reissue_valid | output | 1 | Corrected memory request |
| reissue_idx | output | IDX_W | Entry of the corrected request |
| reissue_pa | output | PA_W | Corrected address |
| reissue_gen | output | 1 | New generation of the corrected request |
| flush_valid | output | 1 | Pipeline flush request |
| flush_idx | output | IDX_W | Oldest entry discarded by the flush |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_idx | output | IDX_W | Index of the retiring entry |
| commit_pa | output | PA_W | Address of the retiring entry |

## Verification
Two functions can coincide. A data reply and a mismatching verification can land on the same entry in one clock, and the bench drives both in the same cycle. It passes only if a reissue comes out, no flush appears, and the entry stays unretired until a reply with the new generation arrives. In a second case, a flush and a new allocation meet in the same cycle: the bench offers an allocation alongside the mismatching verification and expects it to be refused, and the next accepted allocation must reuse the flushed index.

// File: rtl/spec_lsq_pkg.sv
// Package: shared helpers for the speculation-tracking queue.
// Assumes indices are below the ring depth passed in.
package spec_lsq_pkg;
    // Distance going forward around a ring of 'depth' slots from 'from' to 'to'.
    function automatic int unsigned ring_dist(input int unsigned from,
                                              input int unsigned to,
                                              input int unsigned depth);
        if (to >= from) return to - from;
        return to + depth - from;
    endfunction
endpackage

// File: rtl/spec_lsq_slot.sv
// One queue entry: stored address, speculation flag, data-returned flag,
// request generation. Assumes the parent asserts kill on a flush and never
// allocates into an occupied entry.
module spec_lsq_slot #(
    parameter int PA_W = 36
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_en,
    input  logic [PA_W-1:0] alloc_pa,
    input  logic            alloc_spec,
    input  logic            rsp_en,
    input  logic            rsp_gen,
    input  logic            ver_en,
    input  logic [PA_W-1:0] ver_pa,
    input  logic            kill,
    input  logic            retire,
    output logic            done_o,
    output logic            gen_o,
    output logic [PA_W-1:0] pa_o,
    output logic            ready_o,
    output logic            mism_o
);
    logic            valid, spec, done, gen;
    logic [PA_W-1:0] pa;
    logic            rsp_take;

    // Decode verification outcome and reply acceptance for this entry.
    always_comb begin
        mism_o   = ver_en && valid && spec && (pa != ver_pa);
        rsp_take = rsp_en && valid && (rsp_gen == gen) && !done && !mism_o;
    end

    // Entry state update; kill beats allocation beats normal tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            spec  <= 1'b0;
            done  <= 1'b0;
            gen   <= 1'b0;
            pa    <= '0;
        end else if (kill) begin
            valid <= 1'b0;
            spec  <= 1'b0;
            done  <= 1'b0;
        end else if (alloc_en) begin
            valid <= 1'b1;
            spec  <= alloc_spec;
            done  <= 1'b0;
            gen   <= ~gen;
            pa    <= alloc_pa;
        end else begin
            if (retire) valid <= 1'b0;
            if (ver_en && valid && spec) begin
                if (!mism_o) begin
                    spec <= 1'b0;
                end else if (!done) begin
                    pa   <= ver_pa;
                    spec <= 1'b0;
                    gen  <= ~gen;
                end
            end
            if (rsp_take) done <= 1'b1;
        end
    end

    assign done_o  = done;
    assign gen_o   = gen;
    assign pa_o    = pa;
    assign ready_o = valid && done && !spec;

    assert_spec_only_on_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spec) |-> $past(alloc_en));
    assert_reply_gen_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(rsp_en) && ($past(rsp_gen) == $past(gen))));
    assert_reissue_takes_true_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mism_o && !done && !kill && !alloc_en) |=>
            (pa == $past(ver_pa) && !spec && gen != $past(gen) && !done));
endmodule

// File: rtl/spec_lsq_ptrs.sv
// Head/tail/occupancy bookkeeping for the ring. A flush rewinds the tail
// to the flushed index. Assumes push is never raised together with flush.
module spec_lsq_ptrs #(
    parameter int DEPTH = 48,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush_en,
    input  logic [IDX_W-1:0] flush_idx,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    import spec_lsq_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [CNT_W-1:0] keep;

    // Entries that survive a flush, before any same-cycle retire.
    always_comb keep = CNT_W'(ring_dist(int'(head), int'(flush_idx), DEPTH));

    // Advance pointers on push/pop, rewind tail on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop) head <= (head == LAST) ? '0 : head + 1'b1;
            if (flush_en) begin
                tail  <= flush_idx;
                count <= keep - CNT_W'(pop);
            end else begin
                if (push) tail <= (tail == LAST) ? '0 : tail + 1'b1;
                count <= count + CNT_W'(push) - CNT_W'(pop);
            end
        end
    end

    assign full = (count == CNT_W'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_flush_rewinds_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (tail == $past(flush_idx)));
endmodule

// File: rtl/spec_lsq.sv
// Speculation-tracking load/store queue top. Issues each access on
// allocation, checks speculative addresses against walker verification,
// and recovers by reissue (data absent) or flush (data present).
// Assumes at most one allocation, one reply and one verification per cycle.
module spec_lsq #(
    parameter int DEPTH = 48,
    parameter int PA_W  = 36,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [PA_W-1:0]  alloc_pa,
    input  logic             alloc_spec,
    output logic             alloc_ok,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_pa,
    output logic [IDX_W-1:0] mem_req_idx,
    output logic             mem_req_gen,
    input  logic             rsp_valid,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic             rsp_gen,
    input  logic             ver_valid,
    input  logic [IDX_W-1:0] ver_idx,
    input  logic [PA_W-1:0]  ver_pa,
    output logic             reissue_valid,
    output logic [IDX_W-1:0] reissue_idx,
    output logic [PA_W-1:0]  reissue_pa,
    output logic             reissue_gen,
    output logic             flush_valid,
    output logic [IDX_W-1:0] flush_idx,
    output logic             commit_valid,
    output logic [IDX_W-1:0] commit_idx,
    output logic [PA_W-1:0]  commit_pa
);
    import spec_lsq_pkg::*;

    logic [DEPTH-1:0] s_done, s_gen, s_ready, s_mism, s_kill;
    logic [PA_W-1:0]  s_pa [DEPTH];
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             full, push, flush_now, reissue_now;
    logic             sel_mism, sel_done, sel_gen, tail_gen, head_ready;
    logic [PA_W-1:0]  head_pa;

    // Select the verified, head and tail entries' state.
    always_comb begin
        sel_mism = 1'b0; sel_done = 1'b0; sel_gen = 1'b0; tail_gen = 1'b0;
        head_ready = 1'b0; head_pa = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ver_idx == IDX_W'(i)) begin
                sel_mism = s_mism[i]; sel_done = s_done[i]; sel_gen = s_gen[i];
            end
            if (tail == IDX_W'(i)) tail_gen = s_gen[i];
            if (head == IDX_W'(i)) begin
                head_ready = s_ready[i]; head_pa = s_pa[i];
            end
        end
    end

    // Pick the recovery path and gate allocation.
    always_comb begin
        flush_now   = ver_valid && sel_mism && sel_done;
        reissue_now = ver_valid && sel_mism && !sel_done;
        alloc_ok    = !full && !flush_now;
        push        = alloc_valid && alloc_ok;
    end

    // Mark the flushed entry and all younger occupied entries for discard.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            s_kill[i] = flush_now
                && (ring_dist(int'(head), i, DEPTH) >= ring_dist(int'(head), int'(ver_idx), DEPTH))
                && (ring_dist(int'(head), i, DEPTH) < int'(count));
        end
    end

    spec_lsq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(commit_valid),
        .flush_en(flush_now), .flush_idx(ver_idx),
        .head(head), .tail(tail), .count(count), .full(full)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        spec_lsq_slot #(.PA_W(PA_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_en(push && tail == IDX_W'(g)),
            .alloc_pa(alloc_pa), .alloc_spec(alloc_spec),
            .rsp_en(rsp_valid && rsp_idx == IDX_W'(g)), .rsp_gen(rsp_gen),
            .ver_en(ver_valid && ver_idx == IDX_W'(g)), .ver_pa(ver_pa),
            .kill(s_kill[g]),
            .retire(commit_valid && head == IDX_W'(g)),
            .done_o(s_done[g]), .gen_o(s_gen[g]), .pa_o(s_pa[g]),
            .ready_o(s_ready[g]), .mism_o(s_mism[g])
        );
    end

    // Register the recovery requests for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_valid   <= 1'b0;
            flush_idx     <= '0;
            reissue_valid <= 1'b0;
            reissue_idx   <= '0;
            reissue_pa    <= '0;
            reissue_gen   <= 1'b0;
        end else begin
            flush_valid   <= flush_now;
            reissue_valid <= reissue_now;
            if (flush_now) flush_idx <= ver_idx;
            if (reissue_now) begin
                reissue_idx <= ver_idx;
                reissue_pa  <= ver_pa;
                reissue_gen <= ~sel_gen;
            end
        end
    end

    assign mem_req_valid = push;
    assign mem_req_pa    = alloc_pa;
    assign mem_req_idx   = tail;
    assign mem_req_gen   = ~tail_gen;
    assign commit_valid  = head_ready;
    assign commit_idx    = head;
    assign commit_pa     = head_pa;

    assert_flush_follows_verify_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(ver_valid));
    assert_one_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_valid && reissue_valid));
    assert_commit_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> (commit_idx != $past(commit_idx)));
    assert_no_alloc_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_req_valid);
endmodule

// File: tb/test_spec_lsq.sv
module test_spec_lsq;
    localparam int DEPTH = 48;
    localparam int PA_W  = 36;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, alloc_spec = 0, rsp_valid = 0, rsp_gen = 0, ver_valid = 0;
    logic [PA_W-1:0] alloc_pa = '0, ver_pa = '0;
    logic [IDX_W-1:0] rsp_idx = '0, ver_idx = '0;
    logic alloc_ok, mem_req_valid, mem_req_gen, reissue_valid, reissue_gen;
    logic flush_valid, commit_valid;
    logic [PA_W-1:0] mem_req_pa, reissue_pa, commit_pa;
    logic [IDX_W-1:0] mem_req_idx, reissue_idx, flush_idx, commit_idx;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spec_lsq #(.DEPTH(DEPTH), .PA_W(PA_W)) i_spec_lsq (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        alloc_valid = 0; alloc_spec = 0; rsp_valid = 0; ver_valid = 0;
    endtask

    task automatic reset_dut();
        clr(); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // Allocate one entry and check the issued request (R1).
    task automatic alloc_one(input logic [PA_W-1:0] pa, input logic spec,
                             input int exp_idx, input logic exp_gen);
        alloc_valid = 1; alloc_pa = pa; alloc_spec = spec;
        #1;
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'(1));
        chk("R1", "mem_req_idx", 64'(mem_req_idx), 64'(exp_idx));
        chk("R1", "mem_req_gen", 64'(mem_req_gen), 64'(exp_gen));
        chk("R1", "mem_req_pa", 64'(mem_req_pa), 64'(pa));
        @(negedge clk); clr();
    endtask

    task automatic reply(input int idx, input logic gen);
        rsp_valid = 1; rsp_idx = IDX_W'(idx); rsp_gen = gen;
        @(negedge clk); clr();
    endtask

    task automatic verify(input int idx, input logic [PA_W-1:0] pa);
        ver_valid = 1; ver_idx = IDX_W'(idx); ver_pa = pa;
        @(negedge clk); clr();
    endtask

    task automatic t_reset();
        reset_dut(); #1;
        chk("R10", "alloc_ok", 64'(alloc_ok), 64'(1));
        chk("R10", "commit_valid", 64'(commit_valid), 64'(0));
        chk("R10", "flush_valid", 64'(flush_valid), 64'(0));
        chk("R10", "reissue_valid", 64'(reissue_valid), 64'(0));
    endtask

    task automatic t_stale_gen();
        reset_dut();
        alloc_one(36'h1000, 0, 0, 1);
        reply(0, 0); #1;
        chk("R3", "wrong-gen reply ignored", 64'(commit_valid), 64'(0));
        reply(0, 1); #1;
        chk("R8", "commit_valid", 64'(commit_valid), 64'(1));
        chk("R8", "commit_pa", 64'(commit_pa), 64'h1000);
        @(negedge clk); #1;
        chk("R8", "retired once", 64'(commit_valid), 64'(0));
        reply(0, 0); #1;
        chk("R3", "reply to empty entry ignored", 64'(commit_valid), 64'(0));
    endtask

    task automatic t_spec_match();
        reset_dut();
        alloc_one(36'h3760, 1, 0, 1);
        reply(0, 1); #1;
        chk("R2", "speculative data held", 64'(commit_valid), 64'(0));
        verify(0, 36'h3760); #1;
        chk("R4", "match releases", 64'(commit_valid), 64'(1));
        chk("R4", "commit_pa", 64'(commit_pa), 64'h3760);
        chk("R4", "no reissue", 64'(reissue_valid), 64'(0));
    endtask

    task automatic t_nonspec_verify();
        reset_dut();
        alloc_one(36'h2222, 0, 0, 1);
        verify(0, 36'h9999); #1;
        chk("R9", "no flush", 64'(flush_valid), 64'(0));
        chk("R9", "no reissue", 64'(reissue_valid), 64'(0));
        reply(0, 1); #1;
        chk("R9", "address kept", 64'(commit_pa), 64'h2222);
        verify(5, 36'h9999); #1;
        chk("R9", "empty entry: no reissue", 64'(reissue_valid), 64'(0));
    endtask

    task automatic t_reissue();
        reset_dut();
        alloc_one(36'h3760, 1, 0, 1);
        verify(0, 36'h4100); #1;
        chk("R6", "reissue_valid", 64'(reissue_valid), 64'(1));
        chk("R6", "reissue_idx", 64'(reissue_idx), 64'(0));
        chk("R6", "reissue_pa", 64'(reissue_pa), 64'h4100);
        chk("R6", "reissue_gen", 64'(reissue_gen), 64'(0));
        chk("R6", "no flush", 64'(flush_valid), 64'(0));
        reply(0, 1); #1;
        chk("R6", "stale reply dropped", 64'(commit_valid), 64'(0));
        chk("R6", "reissue one cycle", 64'(reissue_valid), 64'(0));
        reply(0, 0); #1;
        chk("R6", "new-gen reply commits", 64'(commit_valid), 64'(1));
        chk("R6", "commit_pa", 64'(commit_pa), 64'h4100);
    endtask

    task automatic t_flush();
        reset_dut();
        alloc_one(36'h100, 0, 0, 1);
        alloc_one(36'h200, 1, 1, 1);
        alloc_one(36'h300, 1, 2, 1);
        reply(1, 1);
        ver_valid = 1; ver_idx = 1; ver_pa = 36'h777;
        alloc_valid = 1; alloc_pa = 36'h400; alloc_spec = 0;
        #1;
        chk("R1", "alloc refused during flush", 64'(alloc_ok), 64'(0));
        chk("R1", "no request during flush", 64'(mem_req_valid), 64'(0));
        @(negedge clk); clr(); #1;
        chk("R5", "flush_valid", 64'(flush_valid), 64'(1));
        chk("R5", "flush_idx", 64'(flush_idx), 64'(1));
        chk("R5", "no reissue", 64'(reissue_valid), 64'(0));
        reply(2, 1); #1;
        chk("R5", "flush one cycle", 64'(flush_valid), 64'(0));
        chk("R5", "head not ready", 64'(commit_valid), 64'(0));
        reply(0, 1); #1;
        chk("R5", "older entry survives", 64'(commit_valid), 64'(1));
        chk("R5", "older commit_idx", 64'(commit_idx), 64'(0));
        @(negedge clk); #1;
        chk("R5", "younger entries gone", 64'(commit_valid), 64'(0));
        alloc_one(36'h500, 0, 1, 0);
    endtask

    task automatic t_collide();
        reset_dut();
        alloc_one(36'h3760, 1, 0, 1);
        rsp_valid = 1; rsp_idx = 0; rsp_gen = 1;
        ver_valid = 1; ver_idx = 0; ver_pa = 36'h5000;
        @(negedge clk); clr(); #1;
        chk("R7", "reissue taken", 64'(reissue_valid), 64'(1));
        chk("R7", "no flush", 64'(flush_valid), 64'(0));
        chk("R7", "reply dropped", 64'(commit_valid), 64'(0));
        reply(0, 0); #1;
        chk("R7", "commit after new reply", 64'(commit_valid), 64'(1));
        chk("R7", "commit_pa", 64'(commit_pa), 64'h5000);
    endtask

    task automatic t_order();
        reset_dut();
        alloc_one(36'hA0, 1, 0, 1);
        alloc_one(36'hB0, 0, 1, 1);
        reply(1, 1); #1;
        chk("R8", "younger waits", 64'(commit_valid), 64'(0));
        reply(0, 1); #1;
        chk("R2", "spec head blocks", 64'(commit_valid), 64'(0));
        verify(0, 36'hA0); #1;
        chk("R8", "head commits", 64'(commit_idx), 64'(0));
        chk("R8", "head commit_valid", 64'(commit_valid), 64'(1));
        @(negedge clk); #1;
        chk("R8", "then younger", 64'(commit_idx), 64'(1));
        chk("R8", "younger pa", 64'(commit_pa), 64'hB0);
        @(negedge clk); #1;
        chk("R8", "queue drained", 64'(commit_valid), 64'(0));
    endtask

    task automatic t_full();
        reset_dut();
        for (int i = 0; i < DEPTH; i++) begin
            alloc_valid = 1; alloc_pa = PA_W'(i); alloc_spec = 0;
            @(negedge clk);
        end
        clr();
        alloc_valid = 1; #1;
        chk("R1", "alloc_ok low when full", 64'(alloc_ok), 64'(0));
        chk("R1", "no request when full", 64'(mem_req_valid), 64'(0));
        @(negedge clk); clr();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stale_gen();
        t_spec_match();
        t_nonspec_verify();
        t_reissue();
        t_flush();
        t_collide();
        t_order();
        t_full();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule